// File: doc/BRIEF.md
# Atomic Lock Window Unit

This unit gives a set of pipelines an atomic read-and-set primitive through ordinary loads and stores. It answers a fixed 16-byte window at the top of the 32-bit address space. Each byte address in the window is its own 32-bit lock word. A load that hits the window returns the word's previous contents and leaves the value one behind, in a single indivisible step. A store that hits the window writes its data into the word, so storing zero releases the lock.

Each port is one memory stage. An uncontended atomic load holds that stage for one extra cycle. The old value appears in the second cycle, together with a busy flag that a multithreaded core can treat like a cache miss and use to switch threads. While one port's atomic operation is in flight, every other port that touches the same word is held off. When ports collide on one word in the same cycle, the lowest-numbered port goes first.

Top module: `tas_lock_unit`

## Requirements
- R1: Only addresses 0xFFFFFFE0 to 0xFFFFFFEF are served. Any other address leaves stall low and read data zero, and changes no lock.
- R2: An atomic load returns the word's previous 32-bit value on the read data in the cycle after its stall cycle, and leaves the value 1 in the word.
- R3: There are 16 independent lock words. Address bits [3:0] pick the word, so an operation on one word leaves every other word unchanged.
- R4: A store to the window writes its data into the chosen word in one cycle, with no stall. A stored zero releases the lock, so the next atomic load returns 0.
- R5: An uncontended atomic load raises stall for exactly one cycle. In the following cycle stall is low and the result is valid.
- R6: In an atomic load's result cycle, the per-port busy output is 1 exactly when the returned old value is non-zero. In every other cycle it is 0.
- R7: After reset every word is zero, and every port shows stall 0, read data 0 and busy 0.
- R8: When several ports hit the same word in the same cycle, the lowest-numbered port is served and every other port is stalled.
- R9: While an atomic load on a word is in progress (its stall cycle and its result cycle), any other port's load or store to that word is stalled and takes effect only after the atomic load completes.
- R10: Ports that hit different words are served in the same cycle, with no stall beyond each port's own atomic cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | NUM_PORTS | Per-port access present this cycle |
| req_we | input | NUM_PORTS | Per-port store (1) or atomic load (0) |
| req_addr | input | NUM_PORTS*ADDR_W | Per-port byte address, port 0 in the low slice |
| req_wdata | input | NUM_PORTS*DATA_W | Per-port store data |
| rsp_stall | output | NUM_PORTS | Hold the memory stage this cycle |
| rsp_rdata | output | NUM_PORTS*DATA_W | Old lock value in the result cycle, else zero |
| rsp_lock_busy | output | NUM_PORTS | Old value was non-zero: switch the thread |

## Verification
Two things can coincide in one cycle: an atomic load on a word, and a second port's access to that same word. The access may start in the same cycle or land in the first port's result cycle. The bench provokes both cases. It presents two atomic loads to one word at once, a store racing an atomic load, and a late arrival during the other port's result cycle. It judges each case by the stall pattern cycle by cycle and by the old values each port finally receives. A deferred store is judged by what a later atomic load reads back.

// File: rtl/tas_pkg.sv
package tas_pkg;
   // Per-port progress of an atomic load
   typedef enum logic {
      PH_IDLE   = 1'b0,   // free to accept a new access
      PH_RESULT = 1'b1    // second cycle: old value is being returned
   } tas_phase_e;

   localparam int unsigned TAS_SET_VALUE = 1;
endpackage

// File: rtl/tas_addr_decode.sv
module tas_addr_decode #(
   parameter int unsigned ADDR_W = 32,
   parameter int unsigned SEL_W  = 4,
   parameter logic [ADDR_W-1:0] BASE_ADDR = 32'hFFFF_FFE0
) (
   input  logic              valid,
   input  logic [ADDR_W-1:0] addr,
   output logic              hit,
   output logic [SEL_W-1:0]  sel
);
   localparam int unsigned TAG_W = ADDR_W - SEL_W;

   assign hit = valid && (addr[ADDR_W-1:SEL_W] == BASE_ADDR[ADDR_W-1:SEL_W]);
   assign sel = addr[SEL_W-1:0];
endmodule

// File: rtl/tas_port_arbiter.sv
module tas_port_arbiter #(
   parameter int unsigned NP    = 2,
   parameter int unsigned SEL_W = 4
) (
   input  logic [NP-1:0]       hit,
   input  logic [NP*SEL_W-1:0] sel,
   input  logic [NP-1:0]       in_result,
   input  logic [NP*SEL_W-1:0] result_sel,
   output logic [NP-1:0]       grant
);
   logic [NP-1:0] fresh;
   assign fresh = hit & ~in_result;

   generate
      if (NP == 1) begin : g_single
         assign grant = fresh;
      end else begin : g_multi
         logic [NP-1:0] blocked;
         always_comb begin
            for (int p = 0; p < NP; p++) begin
               blocked[p] = 1'b0;
               for (int q = 0; q < NP; q++) begin
                  // another port is returning an atomic result on this word
                  if (q != p && in_result[q] &&
                      result_sel[q*SEL_W +: SEL_W] == sel[p*SEL_W +: SEL_W])
                     blocked[p] = 1'b1;
                  // a lower-numbered port claims this word now
                  if (q < p && fresh[q] &&
                      sel[q*SEL_W +: SEL_W] == sel[p*SEL_W +: SEL_W])
                     blocked[p] = 1'b1;
               end
            end
         end
         assign grant = fresh & ~blocked;
      end
   endgenerate
endmodule

// File: rtl/tas_lock_store.sv
module tas_lock_store #(
   parameter int unsigned NP        = 2,
   parameter int unsigned DATA_W    = 32,
   parameter int unsigned NUM_LOCKS = 16,
   parameter int unsigned SEL_W     = 4
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [NP-1:0]               grant,
   input  logic [NP-1:0]               we,
   input  logic [NP*SEL_W-1:0]         sel,
   input  logic [NP*DATA_W-1:0]        wdata,
   output logic [NP*DATA_W-1:0]        old_val,
   output logic [NUM_LOCKS*DATA_W-1:0] lock_flat
);
   localparam logic [DATA_W-1:0] SET_VAL = DATA_W'(tas_pkg::TAS_SET_VALUE);

   logic [DATA_W-1:0] lock_q [NUM_LOCKS];

   generate
      for (genvar i = 0; i < NUM_LOCKS; i++) begin : g_lock
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               lock_q[i] <= '0;
            end else begin
               // granted ports always carry distinct word selects
               for (int p = 0; p < NP; p++) begin
                  if (grant[p] && sel[p*SEL_W +: SEL_W] == SEL_W'(i))
                     lock_q[i] <= we[p] ? wdata[p*DATA_W +: DATA_W] : SET_VAL;
               end
            end
         end
         assign lock_flat[i*DATA_W +: DATA_W] = lock_q[i];
      end

      for (genvar p = 0; p < NP; p++) begin : g_rd
         assign old_val[p*DATA_W +: DATA_W] = lock_q[sel[p*SEL_W +: SEL_W]];
      end
   endgenerate
endmodule

// File: rtl/tas_lock_unit.sv
module tas_lock_unit #(
   parameter int unsigned NUM_PORTS = 2,
   parameter int unsigned ADDR_W    = 32,
   parameter int unsigned DATA_W    = 32,
   parameter int unsigned NUM_LOCKS = 16,
   parameter logic [ADDR_W-1:0] BASE_ADDR = 32'hFFFF_FFE0
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic [NUM_PORTS-1:0]          req_valid,
   input  logic [NUM_PORTS-1:0]          req_we,
   input  logic [NUM_PORTS*ADDR_W-1:0]   req_addr,
   input  logic [NUM_PORTS*DATA_W-1:0]   req_wdata,
   output logic [NUM_PORTS-1:0]          rsp_stall,
   output logic [NUM_PORTS*DATA_W-1:0]   rsp_rdata,
   output logic [NUM_PORTS-1:0]          rsp_lock_busy
);
   import tas_pkg::*;

   localparam int unsigned SEL_W = (NUM_LOCKS > 1) ? $clog2(NUM_LOCKS) : 1;
   localparam int unsigned NP    = NUM_PORTS;

   generate
      if (NUM_PORTS < 1)
         $error("tas_lock_unit: NUM_PORTS must be at least 1");
      if ((1 << SEL_W) != NUM_LOCKS)
         $error("tas_lock_unit: NUM_LOCKS must be a power of two");
      if (SEL_W >= ADDR_W)
         $error("tas_lock_unit: window wider than the address");
      if (DATA_W < 1)
         $error("tas_lock_unit: DATA_W must be positive");
   endgenerate

   logic [NP-1:0]               hit;
   logic [NP*SEL_W-1:0]         sel;
   logic [NP-1:0]               grant;
   logic [NP-1:0]               ph_done;
   logic [NP*SEL_W-1:0]         done_sel;
   logic [NP*DATA_W-1:0]        old_val;
   logic [NUM_LOCKS*DATA_W-1:0] lock_flat;

   tas_phase_e        phase_q [NP];
   logic [SEL_W-1:0]  sel_q   [NP];
   logic [DATA_W-1:0] hold_q  [NP];

   generate
      for (genvar p = 0; p < NP; p++) begin : g_port
         tas_addr_decode #(
            .ADDR_W   (ADDR_W),
            .SEL_W    (SEL_W),
            .BASE_ADDR(BASE_ADDR)
         ) u_dec (
            .valid(req_valid[p]),
            .addr (req_addr[p*ADDR_W +: ADDR_W]),
            .hit  (hit[p]),
            .sel  (sel[p*SEL_W +: SEL_W])
         );

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               phase_q[p] <= PH_IDLE;
               sel_q[p]   <= '0;
               hold_q[p]  <= '0;
            end else if (phase_q[p] == PH_RESULT) begin
               phase_q[p] <= PH_IDLE;
            end else if (grant[p] && !req_we[p]) begin
               phase_q[p] <= PH_RESULT;
               sel_q[p]   <= sel[p*SEL_W +: SEL_W];
               hold_q[p]  <= old_val[p*DATA_W +: DATA_W];
            end
         end

         assign ph_done[p] = (phase_q[p] == PH_RESULT);
         assign done_sel[p*SEL_W +: SEL_W] = sel_q[p];

         // stall: a fresh access that is blocked, or the extra atomic cycle
         assign rsp_stall[p] = hit[p] && !ph_done[p] && (!grant[p] || !req_we[p]);
         assign rsp_rdata[p*DATA_W +: DATA_W] = ph_done[p] ? hold_q[p] : '0;
         assign rsp_lock_busy[p] = ph_done[p] && (hold_q[p] != '0);
      end
   endgenerate

   tas_port_arbiter #(
      .NP   (NP),
      .SEL_W(SEL_W)
   ) u_arb (
      .hit       (hit),
      .sel       (sel),
      .in_result (ph_done),
      .result_sel(done_sel),
      .grant     (grant)
   );

   tas_lock_store #(
      .NP       (NP),
      .DATA_W   (DATA_W),
      .NUM_LOCKS(NUM_LOCKS),
      .SEL_W    (SEL_W)
   ) u_store (
      .clk      (clk),
      .rst_n    (rst_n),
      .grant    (grant),
      .we       (req_we),
      .sel      (sel),
      .wdata    (req_wdata),
      .old_val  (old_val),
      .lock_flat(lock_flat)
   );
endmodule

// File: rtl/tas_lock_unit_chk.sv
module tas_lock_unit_chk #(
   parameter int unsigned NP        = 2,
   parameter int unsigned ADDR_W    = 32,
   parameter int unsigned DATA_W    = 32,
   parameter int unsigned NUM_LOCKS = 16,
   parameter int unsigned SEL_W     = 4,
   parameter logic [ADDR_W-1:0] BASE_ADDR = 32'hFFFF_FFE0
) (
   input logic                        clk,
   input logic                        rst_n,
   input logic [NP-1:0]               req_valid,
   input logic [NP-1:0]               req_we,
   input logic [NP*ADDR_W-1:0]        req_addr,
   input logic [NP-1:0]               rsp_stall,
   input logic [NP*DATA_W-1:0]        rsp_rdata,
   input logic [NP-1:0]               rsp_lock_busy,
   input logic [NP-1:0]               grant,
   input logic [NP-1:0]               ph_done,
   input logic [NP*SEL_W-1:0]         done_sel,
   input logic [NUM_LOCKS*DATA_W-1:0] lock_flat
);
   logic [NP-1:0]       in_win;
   logic [NP*SEL_W-1:0] csel;

   generate
      for (genvar p = 0; p < NP; p++) begin : g_c
         assign in_win[p] = req_addr[p*ADDR_W+SEL_W +: ADDR_W-SEL_W]
                            == BASE_ADDR[ADDR_W-1:SEL_W];
         assign csel[p*SEL_W +: SEL_W] = req_addr[p*ADDR_W +: SEL_W];

         // R1: outside the window nothing answers
         a_r1_outside_quiet: assert property (@(posedge clk) disable iff (!rst_n)
            (req_valid[p] && !in_win[p]) |-> (!rsp_stall[p] && rsp_rdata[p*DATA_W +: DATA_W] == '0));

         // R5: a granted atomic load stalls once, then delivers without stall
         a_r5_one_stall: assert property (@(posedge clk) disable iff (!rst_n)
            (grant[p] && !req_we[p] && !ph_done[p]) |=> (ph_done[p] && !rsp_stall[p]));

         // R2: during the result cycle the word already holds one
         a_r2_word_set: assert property (@(posedge clk) disable iff (!rst_n)
            ph_done[p] |-> (lock_flat[done_sel[p*SEL_W +: SEL_W]*DATA_W +: DATA_W] == DATA_W'(1)));

         // R6: busy only follows an atomic load presented in the cycle before
         a_r6_busy_origin: assert property (@(posedge clk) disable iff (!rst_n)
            rsp_lock_busy[p] |-> $past(req_valid[p] && !req_we[p]));

         for (genvar q = 0; q < NP; q++) begin : g_pair
            if (q != p) begin : g_ne
               // R9: a word in its result cycle holds off every other port
               a_r9_held_off: assert property (@(posedge clk) disable iff (!rst_n)
                  (ph_done[q] && req_valid[p] && in_win[p] && !ph_done[p] &&
                   csel[p*SEL_W +: SEL_W] == done_sel[q*SEL_W +: SEL_W]) |-> rsp_stall[p]);
            end
            if (q > p) begin : g_gt
               // R8: never two grants to one word in a cycle
               a_r8_single_winner: assert property (@(posedge clk) disable iff (!rst_n)
                  !(grant[p] && grant[q] &&
                    csel[p*SEL_W +: SEL_W] == csel[q*SEL_W +: SEL_W]));
            end
         end
      end
   endgenerate
endmodule

bind tas_lock_unit tas_lock_unit_chk #(
   .NP       (NUM_PORTS),
   .ADDR_W   (ADDR_W),
   .DATA_W   (DATA_W),
   .NUM_LOCKS(NUM_LOCKS),
   .SEL_W    (SEL_W),
   .BASE_ADDR(BASE_ADDR)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .req_valid    (req_valid),
   .req_we       (req_we),
   .req_addr     (req_addr),
   .rsp_stall    (rsp_stall),
   .rsp_rdata    (rsp_rdata),
   .rsp_lock_busy(rsp_lock_busy),
   .grant        (grant),
   .ph_done      (ph_done),
   .done_sel     (done_sel),
   .lock_flat    (lock_flat)
);

// File: tb/tas_lock_unit_tb.sv
module tas_lock_unit_tb_top;
   localparam logic [31:0] BASE = 32'hFFFF_FFE0;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  req_valid = '0;
   logic [1:0]  req_we = '0;
   logic [63:0] req_addr = '0;
   logic [63:0] req_wdata = '0;
   logic [1:0]  rsp_stall;
   logic [63:0] rsp_rdata;
   logic [1:0]  rsp_lock_busy;

   int checks = 0;
   int errors = 0;
   int cycles = 0;

   always #2 clk = ~clk;   // 250 MHz

   tas_lock_unit dut_i (
      .clk          (clk),
      .rst_n        (rst_n),
      .req_valid    (req_valid),
      .req_we       (req_we),
      .req_addr     (req_addr),
      .req_wdata    (req_wdata),
      .rsp_stall    (rsp_stall),
      .rsp_rdata    (rsp_rdata),
      .rsp_lock_busy(rsp_lock_busy)
   );

   typedef struct packed {
      logic        is_tas;
      logic [3:0]  sel;
      logic [31:0] wdata;
      logic [31:0] exp_old;
   } vec_t;

   localparam int NV = 12;
   localparam vec_t VEC [NV] = '{
      '{1'b1, 4'd3,  32'h0,         32'h0},          // R7 fresh word reads 0
      '{1'b1, 4'd3,  32'h0,         32'h1},          // R2 second load sees 1
      '{1'b0, 4'd3,  32'h0,         32'h0},          // R4 release
      '{1'b1, 4'd3,  32'h0,         32'h0},          // R4 released reads 0
      '{1'b0, 4'd5,  32'hA5A5_0F0F, 32'h0},          // R4 store data
      '{1'b1, 4'd5,  32'h0,         32'hA5A5_0F0F},  // R4 old data returned
      '{1'b1, 4'd4,  32'h0,         32'h0},          // R3 neighbour untouched
      '{1'b1, 4'd15, 32'h0,         32'h0},          // R3 top of window
      '{1'b1, 4'd0,  32'h0,         32'h0},          // R3 bottom of window
      '{1'b0, 4'd15, 32'h8000_0000, 32'h0},          // R4 store high bit
      '{1'b1, 4'd15, 32'h0,         32'h8000_0000},  // R6 busy on non-zero
      '{1'b1, 4'd0,  32'h0,         32'h1}           // R3 word 0 kept its set
   };

   task automatic check(input bit ok, input string rq, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%h expected=%h", rq, what, act, exp);
      end
   endtask

   task automatic set_req(input int p, input logic v, input logic w,
                          input logic [31:0] a, input logic [31:0] d);
      req_valid[p] = v;
      req_we[p] = w;
      req_addr[p*32 +: 32] = a;
      req_wdata[p*32 +: 32] = d;
   endtask

   task automatic idle_all();
      set_req(0, 1'b0, 1'b0, 32'h0, 32'h0);
      set_req(1, 1'b0, 1'b0, 32'h0, 32'h0);
   endtask

   // All tasks start just after a falling edge and end just after one.
   task automatic do_tas(input int p, input logic [3:0] s, input logic [31:0] exp,
                         input string rq);
      set_req(p, 1'b1, 1'b0, BASE + 32'(s), 32'h0);
      #1;
      check(rsp_stall[p] == 1'b1, "R5", "stall in atomic cycle", 32'(rsp_stall[p]), 32'h1);
      @(negedge clk); #1;
      check(rsp_stall[p] == 1'b0, "R5", "stall in result cycle", 32'(rsp_stall[p]), 32'h0);
      check(rsp_rdata[p*32 +: 32] == exp, rq, "old value", rsp_rdata[p*32 +: 32], exp);
      check(rsp_lock_busy[p] == (exp != 0), "R6", "busy flag",
            32'(rsp_lock_busy[p]), 32'(exp != 0));
      @(negedge clk);
      set_req(p, 1'b0, 1'b0, 32'h0, 32'h0);
   endtask

   task automatic do_store(input int p, input logic [3:0] s, input logic [31:0] d);
      set_req(p, 1'b1, 1'b1, BASE + 32'(s), d);
      #1;
      check(rsp_stall[p] == 1'b0, "R4", "store no stall", 32'(rsp_stall[p]), 32'h0);
      check(rsp_lock_busy[p] == 1'b0, "R6", "no busy on store", 32'(rsp_lock_busy[p]), 32'h0);
      @(negedge clk);
      set_req(p, 1'b0, 1'b0, 32'h0, 32'h0);
   endtask

   task automatic finish_run();
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 5000) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired actual=%0d expected<=5000", cycles);
         finish_run();
      end
   end

   initial begin
      idle_all();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk); #1;
      // R7: quiet outputs after reset
      check(rsp_stall == 2'b00, "R7", "stall after reset", 32'(rsp_stall), 32'h0);
      check(rsp_rdata == 64'h0, "R7", "rdata after reset", rsp_rdata[31:0], 32'h0);
      check(rsp_lock_busy == 2'b00, "R7", "busy after reset", 32'(rsp_lock_busy), 32'h0);
      @(negedge clk);

      // Vector table on port 0
      for (int i = 0; i < NV; i++) begin
         if (VEC[i].is_tas)
            do_tas(0, VEC[i].sel, VEC[i].exp_old, "R2");
         else
            do_store(0, VEC[i].sel, VEC[i].wdata);
      end

      // R1: accesses outside the window
      set_req(0, 1'b1, 1'b0, 32'hFFFF_FFD9, 32'h0);
      #1;
      check(rsp_stall[0] == 1'b0, "R1", "no stall below window", 32'(rsp_stall[0]), 32'h0);
      @(negedge clk); #1;
      check(rsp_rdata[31:0] == 32'h0, "R1", "no data below window", rsp_rdata[31:0], 32'h0);
      @(negedge clk);
      set_req(0, 1'b1, 1'b1, 32'h7FFF_FFE9, 32'h5);
      #1;
      check(rsp_stall[0] == 1'b0, "R1", "no stall on foreign store", 32'(rsp_stall[0]), 32'h0);
      @(negedge clk);
      set_req(0, 1'b0, 1'b0, 32'h0, 32'h0);
      do_tas(0, 4'd9, 32'h0, "R1");

      // R8: both ports, same word, same cycle
      set_req(0, 1'b1, 1'b0, BASE + 32'd6, 32'h0);
      set_req(1, 1'b1, 1'b0, BASE + 32'd6, 32'h0);
      #1;
      check(rsp_stall == 2'b11, "R8", "both stall first cycle", 32'(rsp_stall), 32'h3);
      @(negedge clk); #1;
      check(rsp_stall == 2'b10, "R8", "port1 held in port0 result", 32'(rsp_stall), 32'h2);
      check(rsp_rdata[31:0] == 32'h0, "R8", "port0 wins old 0", rsp_rdata[31:0], 32'h0);
      @(negedge clk);
      set_req(0, 1'b0, 1'b0, 32'h0, 32'h0);
      #1;
      check(rsp_stall[1] == 1'b1, "R8", "port1 atomic cycle", 32'(rsp_stall[1]), 32'h1);
      @(negedge clk); #1;
      check(rsp_stall[1] == 1'b0, "R8", "port1 result no stall", 32'(rsp_stall[1]), 32'h0);
      check(rsp_rdata[63:32] == 32'h1, "R8", "port1 sees set", rsp_rdata[63:32], 32'h1);
      check(rsp_lock_busy[1] == 1'b1, "R6", "port1 busy", 32'(rsp_lock_busy[1]), 32'h1);
      @(negedge clk);
      idle_all();

      // R9: store racing an atomic load on word 7
      set_req(0, 1'b1, 1'b0, BASE + 32'd7, 32'h0);
      set_req(1, 1'b1, 1'b1, BASE + 32'd7, 32'h0);
      #1;
      check(rsp_stall[1] == 1'b1, "R9", "store held in atomic cycle", 32'(rsp_stall[1]), 32'h1);
      @(negedge clk); #1;
      check(rsp_stall[1] == 1'b1, "R9", "store held in result cycle", 32'(rsp_stall[1]), 32'h1);
      check(rsp_rdata[31:0] == 32'h0, "R9", "atomic old 0", rsp_rdata[31:0], 32'h0);
      @(negedge clk);
      set_req(0, 1'b0, 1'b0, 32'h0, 32'h0);
      #1;
      check(rsp_stall[1] == 1'b0, "R9", "store proceeds", 32'(rsp_stall[1]), 32'h0);
      @(negedge clk);
      idle_all();
      do_tas(0, 4'd7, 32'h0, "R9");   // deferred zero store landed after the set

      // R9: port0 arrives during port1 result cycle on word 12
      set_req(1, 1'b1, 1'b0, BASE + 32'd12, 32'h0);
      @(negedge clk);
      set_req(0, 1'b1, 1'b0, BASE + 32'd12, 32'h0);
      #1;
      check(rsp_stall == 2'b01, "R9", "port0 held by port1 result", 32'(rsp_stall), 32'h1);
      check(rsp_rdata[63:32] == 32'h0, "R9", "port1 old 0", rsp_rdata[63:32], 32'h0);
      @(negedge clk);
      set_req(1, 1'b0, 1'b0, 32'h0, 32'h0);
      #1;
      check(rsp_stall[0] == 1'b1, "R9", "port0 atomic cycle", 32'(rsp_stall[0]), 32'h1);
      @(negedge clk); #1;
      check(rsp_rdata[31:0] == 32'h1, "R9", "port0 sees set", rsp_rdata[31:0], 32'h1);
      check(rsp_lock_busy[0] == 1'b1, "R6", "port0 busy", 32'(rsp_lock_busy[0]), 32'h1);
      @(negedge clk);
      idle_all();

      // R10: different words in parallel
      set_req(0, 1'b1, 1'b0, BASE + 32'd10, 32'h0);
      set_req(1, 1'b1, 1'b0, BASE + 32'd11, 32'h0);
      #1;
      check(rsp_stall == 2'b11, "R10", "both atomic cycles", 32'(rsp_stall), 32'h3);
      @(negedge clk); #1;
      check(rsp_stall == 2'b00, "R10", "both results together", 32'(rsp_stall), 32'h0);
      check(rsp_rdata == 64'h0, "R10", "both old 0", rsp_rdata[31:0], 32'h0);
      check(rsp_lock_busy == 2'b00, "R6", "no busy on zero", 32'(rsp_lock_busy), 32'h0);
      @(negedge clk);
      idle_all();
      do_tas(1, 4'd11, 32'h1, "R10");
      do_tas(0, 4'd10, 32'h1, "R10");

      // R7: a reset mid-run clears all words
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      do_tas(0, 4'd15, 32'h0, "R7");

      finish_run();
   end
endmodule